// File: doc/BRIEF.md
# Same-Group Store/Load Address Overlap Detector

This block remembers the stores that have issued so far in the current dispatch group and tells the scheduler, in the same cycle, whether a candidate load may read bytes that one of those stores writes. Each memory access is described by two address operands: an offset-or-index operand and a base operand. Each operand is either a register tag or a signed 16-bit constant, and a per-operand flag bit says which. Each access also carries a size code. When the detector raises its hit flag, the scheduler inserts no-op padding rather than let the load share a group with the store.

A store is recorded by pulsing its strobe together with its two operands and its size code. The record becomes visible to loads from the next cycle. A load is queried by driving its operands and size with its valid bit high, and the hit flag answers combinationally in that same cycle. A group-clear strobe throws away every record when the dispatch group closes. All ports accept on every cycle. There is no back-pressure on either stream. A store that finds the table full is dropped, and a sticky overflow flag reports the drop until the next clear.

Top module: `sld_overlap_detect`

## Requirements
- R1: A valid load hits when its offset operand equals a recorded store's offset operand and its base operand equals that store's base operand. Equality covers both the constant flag and the 16-bit value.
- R2: A valid load hits when its offset operand equals a store's base operand and its base operand equals that store's offset operand (the commuted pairing).
- R3: When the base operands are equal and both offset operands are constants, the offsets are compared as signed 16-bit values using 18-bit arithmetic that cannot wrap. If the store offset is lower, the load hits when store offset plus store bytes exceeds the load offset. Otherwise, it hits when load offset plus load bytes exceeds the store offset.
- R4: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes.
- R5: A store strobe appends one record. The record takes part in load checks from the following cycle, and not in the cycle of its own strobe.
- R6: The hit flag is low whenever the load valid bit is low or no store has been recorded.
- R7: Group clear discards all records and clears the overflow flag from the next cycle. A load queried in the clear cycle still sees the old records. A store strobed in the clear cycle becomes the first record of the new group.
- R8: The table holds DEPTH (default 4) records. A store arriving when it is full is not recorded, and the overflow flag goes high on the next cycle and stays high until a clear.
- R9: The hit flag is the OR of the match results over all recorded entries, whatever slot the matching store occupies.
- R10: A load whose operands meet none of the R1 to R3 conditions for any record does not hit. This includes a differing base, and a register offset facing a constant offset.
- R11: After reset the table is empty and the overflow flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_clr | input | 1 | Dispatch-group end: discard all records |
| st_valid | input | 1 | Record a store this cycle |
| st_idx_k | input | 1 | Store offset operand is a constant |
| st_idx_v | input | 16 | Store offset operand value or register tag |
| st_base_k | input | 1 | Store base operand is a constant |
| st_base_v | input | 16 | Store base operand value or register tag |
| st_size | input | 3 | Store size code |
| ld_valid | input | 1 | Load query valid |
| ld_idx_k | input | 1 | Load offset operand is a constant |
| ld_idx_v | input | 16 | Load offset operand value or register tag |
| ld_base_k | input | 1 | Load base operand is a constant |
| ld_base_v | input | 16 | Load base operand value or register tag |
| ld_size | input | 3 | Load size code |
| ld_hit | output | 1 | Load may overlap a store of this group |
| st_overflow | output | 1 | Sticky: a store was dropped because the table was full |

## Verification
The embedded properties watch on every cycle the bookkeeping of the record count: its bound, how it clears, how it steps on each accepted store, and the rise and hold of the overflow flag. They also watch that the hit flag stays low with no query or an empty table. The matching rules themselves (exact and commuted pairs, the signed byte-range comparison near its boundaries, the size decode, wide offsets that would wrap at 16 bits) can only be shown by the bench's chosen load and store patterns. The same goes for the visibility timing around store and clear cycles.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned SZC_W  = 3;
  localparam int unsigned BYTE_W = 5;
  localparam int unsigned SUM_W  = OFS_W + 2;

  typedef struct packed {
    logic             k;
    logic [OFS_W-1:0] v;
  } sld_opnd_t;

  typedef struct packed {
    sld_opnd_t        idx;
    sld_opnd_t        base;
    logic [SZC_W-1:0] size;
  } sld_rec_t;

  // R4: size code to byte count, codes above 4 saturate at 16
  function automatic logic [BYTE_W-1:0] sld_bytes(input logic [SZC_W-1:0] code);
    logic [BYTE_W-1:0] n;
    case (code)
      3'd0:    n = 5'd1;
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd4;
      3'd3:    n = 5'd8;
      default: n = 5'd16;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sld_range_chk.sv
module sld_range_chk
  import sld_pkg::*;
(
  input  logic [OFS_W-1:0] st_ofs,
  input  logic [SZC_W-1:0] st_size,
  input  logic [OFS_W-1:0] ld_ofs,
  input  logic [SZC_W-1:0] ld_size,
  output logic             overlap
);
  logic signed [SUM_W-1:0] st_w, ld_w, st_end, ld_end;

  always_comb begin
    st_w   = SUM_W'(signed'(st_ofs));
    ld_w   = SUM_W'(signed'(ld_ofs));
    st_end = st_w + signed'(SUM_W'(sld_bytes(st_size)));
    ld_end = ld_w + signed'(SUM_W'(sld_bytes(ld_size)));
    // R3: the lower access's end must pass the higher start
    if (st_w < ld_w) overlap = (st_end > ld_w);
    else             overlap = (ld_end > st_w);
  end
endmodule

// File: rtl/sld_entry_cmp.sv
module sld_entry_cmp
  import sld_pkg::*;
(
  input  sld_rec_t         rec,
  input  logic             rec_vld,
  input  sld_opnd_t        ld_idx,
  input  sld_opnd_t        ld_base,
  input  logic [SZC_W-1:0] ld_size,
  output logic             hit
);
  logic same_order, swapped, base_eq, both_const, rng_ovl;

  assign same_order = (ld_idx == rec.idx) && (ld_base == rec.base);   // R1
  assign swapped    = (ld_idx == rec.base) && (ld_base == rec.idx);   // R2
  assign base_eq    = (ld_base == rec.base);
  assign both_const = ld_idx.k && rec.idx.k;

  sld_range_chk u_rng (
    .st_ofs  (rec.idx.v),
    .st_size (rec.size),
    .ld_ofs  (ld_idx.v),
    .ld_size (ld_size),
    .overlap (rng_ovl)
  );

  assign hit = rec_vld && (same_order || swapped || (base_eq && both_const && rng_ovl));
endmodule

// File: rtl/sld_store_table.sv
module sld_store_table
  import sld_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  sld_rec_t               wr_rec,
  output sld_rec_t [DEPTH-1:0]   recs,
  output logic     [DEPTH-1:0]   vld,
  output logic                   ovf
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic             full, accept, drop;

  assign cnt_base = clr ? '0 : cnt_q;            // R7: clear acts before the write
  assign full     = (cnt_base == CNT_W'(DEPTH));
  assign accept   = wr_en && !full;
  assign drop     = wr_en && full;               // R8

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      cnt_q <= cnt_base + CNT_W'(accept);
      ovf   <= (ovf && !clr) || drop;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   recs[i] <= '0;
      else if (accept && cnt_base == CNT_W'(i))     recs[i] <= wr_rec;
    end
    assign vld[i] = (CNT_W'(i) < cnt_q);
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_clr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> (cnt_q == '0));
  p_clr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_en) |=> (cnt_q == CNT_W'(1)));
  p_append_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_en && cnt_q < CNT_W'(DEPTH)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wr_en && cnt_q == CNT_W'(DEPTH)) |=> (ovf && cnt_q == CNT_W'(DEPTH)));
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovf);
endmodule

// File: rtl/sld_overlap_detect.sv
module sld_overlap_detect
  import sld_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_clr,
  input  logic             st_valid,
  input  logic             st_idx_k,
  input  logic [OFS_W-1:0] st_idx_v,
  input  logic             st_base_k,
  input  logic [OFS_W-1:0] st_base_v,
  input  logic [SZC_W-1:0] st_size,
  input  logic             ld_valid,
  input  logic             ld_idx_k,
  input  logic [OFS_W-1:0] ld_idx_v,
  input  logic             ld_base_k,
  input  logic [OFS_W-1:0] ld_base_v,
  input  logic [SZC_W-1:0] ld_size,
  output logic             ld_hit,
  output logic             st_overflow
);
  sld_rec_t               wr_rec;
  sld_rec_t [DEPTH-1:0]   recs;
  logic     [DEPTH-1:0]   vld;
  logic     [DEPTH-1:0]   slot_hit;
  sld_opnd_t              q_idx, q_base;

  assign wr_rec.idx  = '{k: st_idx_k,  v: st_idx_v};
  assign wr_rec.base = '{k: st_base_k, v: st_base_v};
  assign wr_rec.size = st_size;
  assign q_idx       = '{k: ld_idx_k,  v: ld_idx_v};
  assign q_base      = '{k: ld_base_k, v: ld_base_v};

  sld_store_table #(.DEPTH(DEPTH)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (grp_clr),
    .wr_en  (st_valid),
    .wr_rec (wr_rec),
    .recs   (recs),
    .vld    (vld),
    .ovf    (st_overflow)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    sld_entry_cmp u_cmp (
      .rec     (recs[i]),
      .rec_vld (vld[i]),
      .ld_idx  (q_idx),
      .ld_base (q_base),
      .ld_size (ld_size),
      .hit     (slot_hit[i])
    );
  end

  assign ld_hit = ld_valid && (|slot_hit);   // R9

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hit);
  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !ld_hit);
  p_fresh_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grp_clr) && !$past(st_valid)) |-> !ld_hit);
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(!rst_n) |-> (!st_overflow && vld == '0));
endmodule

// File: tb/sld_overlap_detect_tb_top.sv
module sld_overlap_detect_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_clr = 0, st_valid = 0, st_idx_k = 0, st_base_k = 0;
  logic ld_valid = 0, ld_idx_k = 0, ld_base_k = 0;
  logic [15:0] st_idx_v = 0, st_base_v = 0, ld_idx_v = 0, ld_base_v = 0;
  logic [2:0] st_size = 0, ld_size = 0;
  logic ld_hit, st_overflow;

  always #10 clk = ~clk;   // 50 MHz

  sld_overlap_detect dut_i (
    .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr),
    .st_valid(st_valid), .st_idx_k(st_idx_k), .st_idx_v(st_idx_v),
    .st_base_k(st_base_k), .st_base_v(st_base_v), .st_size(st_size),
    .ld_valid(ld_valid), .ld_idx_k(ld_idx_k), .ld_idx_v(ld_idx_v),
    .ld_base_k(ld_base_k), .ld_base_v(ld_base_v), .ld_size(ld_size),
    .ld_hit(ld_hit), .st_overflow(st_overflow)
  );

  typedef struct { logic hit; logic ovf; string tag; } exp_t;
  exp_t sb_q[$];
  int n_chk = 0, n_err = 0;

  function automatic logic [16:0] RG(input int t); return {1'b0, 16'(t)}; endfunction
  function automatic logic [16:0] CN(input int c); return {1'b1, 16'(c)}; endfunction
  localparam logic [16:0] NONE = 17'd0;

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input logic clr, input logic sv, input logic [16:0] sa, input logic [16:0] sb,
                      input logic [2:0] ss, input logic lv, input logic [16:0] la,
                      input logic [16:0] lb, input logic [2:0] ls,
                      input logic eh, input logic eo, input string tag);
    exp_t e;
    @(negedge clk);
    grp_clr = clr; st_valid = sv;
    {st_idx_k, st_idx_v} = sa; {st_base_k, st_base_v} = sb; st_size = ss;
    ld_valid = lv; {ld_idx_k, ld_idx_v} = la; {ld_base_k, ld_base_v} = lb; ld_size = ls;
    e.hit = eh; e.ovf = eo; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic store(input logic [16:0] sa, input logic [16:0] sb, input logic [2:0] ss,
                       input logic eo, input string tag);
    step(0, 1, sa, sb, ss, 0, NONE, NONE, 0, 0, eo, tag);
  endtask

  task automatic load(input logic [16:0] la, input logic [16:0] lb, input logic [2:0] ls,
                      input logic eh, input logic eo, input string tag);
    step(0, 0, NONE, NONE, 0, 1, la, lb, ls, eh, eo, tag);
  endtask

  // monitor: compare a quarter period after the driving edge
  always begin
    @(negedge clk);
    #5;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk += 2;
      if (ld_hit !== e.hit) begin
        n_err++;
        $display("FAIL %s ld_hit actual=%b expected=%b", e.tag, ld_hit, e.hit);
      end
      if (st_overflow !== e.ovf) begin
        n_err++;
        $display("FAIL %s st_overflow actual=%b expected=%b", e.tag, st_overflow, e.ovf);
      end
    end
  end

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    load(CN(8), RG(3), 2, 0, 0, "R11 reset empty");
    // R5: same-cycle store not visible
    step(0, 1, CN(8), RG(3), 2, 1, CN(8), RG(3), 2, 0, 0, "R5 same cycle store");
    load(CN(8), RG(3), 2, 1, 0, "R1 exact pair");
    step(0, 0, NONE, NONE, 0, 0, CN(8), RG(3), 2, 0, 0, "R6 no load valid");
    load(RG(3), CN(8), 2, 1, 0, "R2 commuted pair");
    load(CN(12), RG(3), 2, 0, 0, "R3 store end equals load start");
    load(CN(11), RG(3), 0, 1, 0, "R3 store covers load");
    load(CN(6), RG(3), 1, 0, 0, "R4 halfword ends at store");
    load(CN(6), RG(3), 2, 1, 0, "R4 word reaches store");
    load(CN(7), RG(4), 2, 0, 0, "R10 different base");
    load(RG(7), RG(3), 2, 0, 0, "R10 register offset");
    step(1, 0, NONE, NONE, 0, 1, CN(8), RG(3), 2, 1, 0, "R7 clear cycle sees old");
    load(CN(8), RG(3), 2, 0, 0, "R7 after clear");
    // signed and wide offsets
    store(CN(-4), RG(5), 3, 0, "R3 store neg");
    store(CN(16'h7FF8), RG(6), 4, 0, "R4 store 16B");
    store(CN(0), RG(9), 7, 0, "R4 store code7");
    load(CN(2), RG(5), 0, 1, 0, "R3 negative offset overlap");
    load(CN(4), RG(5), 0, 0, 0, "R3 negative offset boundary");
    load(CN(16'h7FFF), RG(6), 0, 1, 0, "R3 no 16-bit wrap");
    load(CN(15), RG(9), 0, 1, 0, "R4 code7 as 16 bytes");
    load(CN(16), RG(9), 0, 0, 0, "R4 code7 boundary");
    // fill and overflow
    step(1, 0, NONE, NONE, 0, 0, NONE, NONE, 0, 0, 0, "R7 clear");
    for (int i = 0; i < 4; i++) store(RG(20 + i), RG(10), 2, 0, "R8 fill");
    store(RG(30), RG(10), 2, 0, "R8 store when full");
    load(RG(30), RG(10), 2, 0, 1, "R8 dropped store");
    load(RG(23), RG(10), 2, 1, 1, "R9 last slot match");
    load(RG(20), RG(10), 2, 1, 1, "R9 first slot match");
    step(1, 1, CN(0), RG(1), 2, 0, NONE, NONE, 0, 0, 1, "R7 clear with store");
    load(CN(0), RG(1), 2, 1, 0, "R7 store in clear cycle kept");
    load(RG(20), RG(10), 2, 0, 0, "R7 old entries gone");
    step(0, 0, NONE, NONE, 0, 0, NONE, NONE, 0, 0, 0, "idle");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule